// File: doc/BRIEF.md
# Shift and Rotate Unit with Flags

This block is the shift and rotate slice of an integer execution pipeline. It takes one operation per cycle and returns the result and the carry and overflow flag updates on the following cycle. It performs a left shift, a logical right shift, an arithmetic right shift, plain rotates in both directions, and rotates in both directions that pass through the carry. The caller picks a 64-bit or 32-bit operand width. In 32-bit mode only the low half of the source is used, and the upper half of the result is zero.

The amount comes from one of two 6-bit inputs, a register field or an immediate field, chosen by a select bit. It is masked to the width in use. The flag outputs come as values plus write strobes. The caller asks, bit by bit, which of the carry, extended-carry and overflow flags it wants written. The unit raises a strobe only when it was asked and the operation actually moved bits. A zero effective amount leaves every flag alone.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation codes are 0 left shift, 1 logical right shift (zero fill), 2 arithmetic right shift (fill with copies of the operand's top bit), 3 rotate left, 4 rotate right, 5 rotate left through carry, 6 rotate right through carry. The result of each matches that operation on the operand.
- R2: Plain rotates move bits leaving one end of the operand into the other end, at the operand width.
- R3: Through-carry rotates rotate a ring of width+1 bits, with the incoming carry as its top bit. The result is the low width bits of the rotated ring, and the new carry is the bit that ends up in the carry position.
- R4: `wide`=1 selects 64-bit operands. `wide`=0 uses `srcVal[31:0]`, takes bit 31 as the top bit, and drives `resultOut[63:32]` to zero.
- R5: `useImm`=1 takes the amount from `amtImm`, otherwise from `amtReg`. In 32-bit mode only the low 5 bits of the amount count; in 64-bit mode all 6 count.
- R6: If the effective amount is zero, no flag strobe is raised and the result equals the width-masked operand.
- R7: For shifts, the carry is the last bit shifted out. Overflow is the new carry XOR the result's top bit for the left shift, the operand's original top bit for the logical right shift, and 0 for the arithmetic right shift.
- R8: For rotate right, the carry is the result's top bit and overflow is the XOR of the operand's two top bits. For rotate left, the carry is the result's bottom bit and overflow is the result's top bit XOR its bottom bit.
- R9: For rotate left through carry, overflow is the old carry XOR the result's top bit. For rotate right through carry, overflow is the old carry XOR the operand's original top bit.
- R10: `flagReq` bit 0 requests the carry, bit 1 the extended carry and bit 2 the overflow. A strobe rises only if its bit was set. The extended carry takes its value from `cfOut`.
- R11: Outputs register one cycle after an accepted input (`inValid`). With no input there is no `outValid` and no strobe. Reset clears every output.
- R12: Operation code 7 returns the width-masked operand and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| opCode | input | 3 | Operation selector |
| wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| srcVal | input | 64 | Operand |
| amtReg | input | 6 | Amount from the register field |
| amtImm | input | 6 | Amount from the immediate field |
| useImm | input | 1 | Select the immediate amount |
| cfIn | input | 1 | Current carry flag |
| flagReq | input | 3 | Requested flag writes (CF, ECF, OF) |
| outValid | output | 1 | Result valid |
| resultOut | output | 64 | Shift or rotate result |
| cfWrEn | output | 1 | Write carry flag |
| ecfWrEn | output | 1 | Write extended carry flag |
| ofWrEn | output | 1 | Write overflow flag |
| cfOut | output | 1 | New carry / extended-carry value |
| ofOut | output | 1 | New overflow value |

## Verification
The bench targets amounts that reduce to zero only after masking, such as 32 in 32-bit mode. A unit that masks to the wrong width there would shift or write flags when it should leave them alone. It drives through-carry rotates at both widths and with the carry set. A ring that leaves out the carry bit, or that is built at the wrong width, returns a wrong bit at the seam and a wrong carry. It gives each operation operands whose top two bits differ. That separates overflow taken from the original operand from overflow taken from the result, and catches a design that swaps them. Random traffic with partial flag requests and idle cycles catches strobes that leak without a request or without a valid input.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_RCL = 3'd5,
    OP_RCR = 3'd6,
    OP_NOP = 3'd7
  } shOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  capture;
    logic  wide;
    shOp_e op;
  } shStrobe_t;

endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
  import shrot_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  localparam int AMT_W   = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [2:0]       opCode,
  input  logic             wide,
  input  logic [AMT_W-1:0] amtReg,
  input  logic [AMT_W-1:0] amtImm,
  input  logic             useImm,
  input  logic [2:0]       flagReq,
  output shStrobe_t        strb,
  output logic [AMT_W-1:0] effAmt,
  output logic             outValid,
  output logic             cfWrEn,
  output logic             ecfWrEn,
  output logic             ofWrEn
);

  localparam logic [AMT_W-1:0] NARROW_MASK = AMT_W'(NARROW_W - 1);

  logic [AMT_W-1:0] rawAmt;
  logic             amtZero;
  logic             flagOk;
  logic [2:0]       weNext;

  always_comb begin
    rawAmt       = useImm ? amtImm : amtReg;
    effAmt       = wide ? rawAmt : (rawAmt & NARROW_MASK);
    amtZero      = (effAmt == '0);
    strb.capture = inValid;
    strb.wide    = wide;
    strb.op      = shOp_e'(opCode);
    flagOk       = inValid && !amtZero && (strb.op != OP_NOP);
    weNext       = flagOk ? flagReq : 3'b000;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      cfWrEn   <= 1'b0;
      ecfWrEn  <= 1'b0;
      ofWrEn   <= 1'b0;
    end else begin
      outValid <= inValid;
      cfWrEn   <= weNext[0];
      ecfWrEn  <= weNext[1];
      ofWrEn   <= weNext[2];
    end
  end

  // R11
  strobe_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfWrEn || ecfWrEn || ofWrEn) |-> outValid);

  // R6
  zero_amt_no_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && effAmt == '0) |=> !(cfWrEn || ecfWrEn || ofWrEn));

  // R10
  ecf_only_on_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !flagReq[1]) |=> !ecfWrEn);

endmodule

// File: rtl/shrot_datapath.sv
module shrot_datapath
  import shrot_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  localparam int AMT_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  shStrobe_t         strb,
  input  logic [AMT_W-1:0]  effAmt,
  input  logic [DATA_W-1:0] srcVal,
  input  logic              cfIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              cfOut,
  output logic              ofOut
);

  localparam int CNT_W  = AMT_W + 1;
  localparam int RING_W = DATA_W + 1;

  function automatic logic topOf(input logic [DATA_W-1:0] x, input logic wd);
    return wd ? x[DATA_W-1] : x[NARROW_W-1];
  endfunction

  logic [DATA_W-1:0] widthMask, opnd, opndSx;
  logic [RING_W-1:0] ringMask, ring;
  logic [CNT_W-1:0]  wLen, rotBack, ringBack;
  logic              origTop, origSec;

  always_comb begin
    widthMask = strb.wide ? {DATA_W{1'b1}}
                          : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    ringMask  = strb.wide ? {RING_W{1'b1}}
                          : {{(DATA_W-NARROW_W){1'b0}}, {(NARROW_W+1){1'b1}}};
    opnd      = srcVal & widthMask;
    opndSx    = strb.wide ? srcVal
                          : {{(DATA_W-NARROW_W){srcVal[NARROW_W-1]}}, srcVal[NARROW_W-1:0]};
    wLen      = strb.wide ? CNT_W'(DATA_W) : CNT_W'(NARROW_W);
    rotBack   = wLen - CNT_W'(effAmt);
    ringBack  = wLen + CNT_W'(1) - CNT_W'(effAmt);
    ring      = {1'b0, opnd} | ({{DATA_W{1'b0}}, cfIn} << wLen);
    origTop   = strb.wide ? srcVal[DATA_W-1] : srcVal[NARROW_W-1];
    origSec   = strb.wide ? srcVal[DATA_W-2] : srcVal[NARROW_W-2];
  end

  // shifts: one spare bit catches the last bit moved out
  logic [RING_W-1:0]        shlExt, shrExt;
  logic signed [RING_W-1:0] sarIn, sarExt;
  logic [DATA_W-1:0]        shlRes, shrRes, sarRes;
  logic                     shlCf;

  always_comb begin
    shlExt = {1'b0, opnd} << effAmt;
    shlRes = shlExt[DATA_W-1:0] & widthMask;
    shlCf  = strb.wide ? shlExt[DATA_W] : shlExt[NARROW_W];
    shrExt = {opnd, 1'b0} >> effAmt;
    shrRes = shrExt[RING_W-1:1];
    sarIn  = {opndSx, 1'b0};
    sarExt = sarIn >>> effAmt;
    sarRes = sarExt[RING_W-1:1] & widthMask;
  end

  // plain rotates
  logic [DATA_W-1:0] rolRes, rorRes;

  always_comb begin
    rolRes = ((opnd << effAmt) | (opnd >> rotBack)) & widthMask;
    rorRes = ((opnd >> effAmt) | (opnd << rotBack)) & widthMask;
  end

  // through-carry rotates on a width+1 ring
  logic [RING_W-1:0] rclRing, rcrRing;
  logic [DATA_W-1:0] rclRes, rcrRes;
  logic              rclCf, rcrCf;

  always_comb begin
    rclRing = ((ring << effAmt) | (ring >> ringBack)) & ringMask;
    rcrRing = ((ring >> effAmt) | (ring << ringBack)) & ringMask;
    rclRes  = rclRing[DATA_W-1:0] & widthMask;
    rcrRes  = rcrRing[DATA_W-1:0] & widthMask;
    rclCf   = strb.wide ? rclRing[DATA_W] : rclRing[NARROW_W];
    rcrCf   = strb.wide ? rcrRing[DATA_W] : rcrRing[NARROW_W];
  end

  // select result and flag values
  logic [DATA_W-1:0] nextRes;
  logic              nextCf, nextOf;

  always_comb begin
    nextRes = opnd;
    nextCf  = 1'b0;
    nextOf  = 1'b0;
    unique case (strb.op)
      OP_SHL: begin
        nextRes = shlRes;
        nextCf  = shlCf;
        nextOf  = shlCf ^ topOf(shlRes, strb.wide);
      end
      OP_SHR: begin
        nextRes = shrRes;
        nextCf  = shrExt[0];
        nextOf  = origTop;
      end
      OP_SAR: begin
        nextRes = sarRes;
        nextCf  = sarExt[0];
        nextOf  = 1'b0;
      end
      OP_ROL: begin
        nextRes = rolRes;
        nextCf  = rolRes[0];
        nextOf  = topOf(rolRes, strb.wide) ^ rolRes[0];
      end
      OP_ROR: begin
        nextRes = rorRes;
        nextCf  = topOf(rorRes, strb.wide);
        nextOf  = origTop ^ origSec;
      end
      OP_RCL: begin
        nextRes = rclRes;
        nextCf  = rclCf;
        nextOf  = cfIn ^ topOf(rclRes, strb.wide);
      end
      OP_RCR: begin
        nextRes = rcrRes;
        nextCf  = rcrCf;
        nextOf  = cfIn ^ origTop;
      end
      default: begin
        nextRes = opnd;
        nextCf  = 1'b0;
        nextOf  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut <= '0;
      cfOut     <= 1'b0;
      ofOut     <= 1'b0;
    end else if (strb.capture) begin
      resultOut <= nextRes;
      cfOut     <= nextCf;
      ofOut     <= nextOf;
    end
  end

  // R4
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.wide) |=> (resultOut[DATA_W-1:NARROW_W] == '0));

  // R7
  sar_of_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && strb.op == OP_SAR) |=> !ofOut);

  // R6
  zero_amt_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && effAmt == '0) |=> (resultOut == $past(opnd)));

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  localparam int AMT_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        opCode,
  input  logic              wide,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [AMT_W-1:0]  amtReg,
  input  logic [AMT_W-1:0]  amtImm,
  input  logic              useImm,
  input  logic              cfIn,
  input  logic [2:0]        flagReq,
  output logic              outValid,
  output logic [DATA_W-1:0] resultOut,
  output logic              cfWrEn,
  output logic              ecfWrEn,
  output logic              ofWrEn,
  output logic              cfOut,
  output logic              ofOut
);

  shStrobe_t        strb;
  logic [AMT_W-1:0] effAmt;

  shrot_ctrl #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opCode   (opCode),
    .wide     (wide),
    .amtReg   (amtReg),
    .amtImm   (amtImm),
    .useImm   (useImm),
    .flagReq  (flagReq),
    .strb     (strb),
    .effAmt   (effAmt),
    .outValid (outValid),
    .cfWrEn   (cfWrEn),
    .ecfWrEn  (ecfWrEn),
    .ofWrEn   (ofWrEn)
  );

  shrot_datapath #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .effAmt    (effAmt),
    .srcVal    (srcVal),
    .cfIn      (cfIn),
    .resultOut (resultOut),
    .cfOut     (cfOut),
    .ofOut     (ofOut)
  );

endmodule

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic        wide = 1'b0;
  logic [63:0] srcVal = '0;
  logic [5:0]  amtReg = '0;
  logic [5:0]  amtImm = '0;
  logic        useImm = 1'b0;
  logic        cfIn = 1'b0;
  logic [2:0]  flagReq = '0;
  logic        outValid, cfWrEn, ecfWrEn, ofWrEn, cfOut, ofOut;
  logic [63:0] resultOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_rotate_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode), .wide(wide),
    .srcVal(srcVal), .amtReg(amtReg), .amtImm(amtImm), .useImm(useImm),
    .cfIn(cfIn), .flagReq(flagReq), .outValid(outValid), .resultOut(resultOut),
    .cfWrEn(cfWrEn), .ecfWrEn(ecfWrEn), .ofWrEn(ofWrEn), .cfOut(cfOut), .ofOut(ofOut)
  );

  // behavioural model: one bit per step
  function automatic void refModel(input int op, input bit wd, input logic [63:0] src,
                                   input int n, input bit cin,
                                   output logic [63:0] r, output bit c, output bit o);
    int w;
    logic [63:0] m, v;
    bit t, topO, secO;
    w = wd ? 64 : 32;
    m = wd ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    v = src & m;
    c = cin;
    o = 1'b0;
    topO = v[w-1];
    secO = v[w-2];
    for (int i = 0; i < n; i++) begin
      case (op)
        0: begin c = v[w-1]; v = (v << 1) & m; end
        1: begin c = v[0]; v = v >> 1; end
        2: begin c = v[0]; t = v[w-1]; v = (v >> 1) | (64'(t) << (w-1)); end
        3: begin t = v[w-1]; v = ((v << 1) | 64'(t)) & m; c = t; end
        4: begin t = v[0]; v = (v >> 1) | (64'(t) << (w-1)); c = t; end
        5: begin t = v[w-1]; v = ((v << 1) | 64'(c)) & m; c = t; end
        6: begin t = v[0]; v = (v >> 1) | (64'(c) << (w-1)); c = t; end
        default: ;
      endcase
    end
    case (op)
      0: o = c ^ v[w-1];
      1: o = topO;
      2: o = 1'b0;
      3: begin c = v[0]; o = v[w-1] ^ v[0]; end
      4: begin c = v[w-1]; o = topO ^ secO; end
      5: o = cin ^ v[w-1];
      6: o = cin ^ topO;
      default: begin c = 1'b0; o = 1'b0; end
    endcase
    r = v;
  endfunction

  task automatic report(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    mismatched++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  // drive one cycle of stimulus, then compare one cycle later
  task automatic stepOp(input bit vld, input int op, input bit wd, input logic [63:0] src,
                        input logic [5:0] ar, input logic [5:0] ai, input bit ui,
                        input bit cin, input logic [2:0] req, input string tag);
    logic [63:0] er;
    bit ec, eo, eCfWe, eEcfWe, eOfWe;
    int n;
    bit bad;
    n = ui ? int'(ai) : int'(ar);
    n = wd ? (n % 64) : (n % 32);
    refModel(op, wd, src, n, cin, er, ec, eo);
    eCfWe  = vld && n != 0 && op != 7 && req[0];
    eEcfWe = vld && n != 0 && op != 7 && req[1];
    eOfWe  = vld && n != 0 && op != 7 && req[2];
    inValid = vld; opCode = 3'(op); wide = wd; srcVal = src;
    amtReg = ar; amtImm = ai; useImm = ui; cfIn = cin; flagReq = req;
    @(posedge clk);
    #1;
    compared++;
    bad = 0;
    if (outValid !== vld) begin report(tag, "outValid", 64'(outValid), 64'(vld)); bad = 1; end
    if (!bad && cfWrEn !== eCfWe) begin report(tag, "cfWrEn", 64'(cfWrEn), 64'(eCfWe)); bad = 1; end
    if (!bad && ecfWrEn !== eEcfWe) begin report(tag, "ecfWrEn", 64'(ecfWrEn), 64'(eEcfWe)); bad = 1; end
    if (!bad && ofWrEn !== eOfWe) begin report(tag, "ofWrEn", 64'(ofWrEn), 64'(eOfWe)); bad = 1; end
    if (!bad && vld && resultOut !== er) begin report(tag, "result", resultOut, er); bad = 1; end
    if (!bad && (eCfWe || eEcfWe) && cfOut !== ec) begin report(tag, "cfOut", 64'(cfOut), 64'(ec)); bad = 1; end
    if (!bad && eOfWe && ofOut !== eo) begin report(tag, "ofOut", 64'(ofOut), 64'(eo)); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    compared++;
    if (outValid !== 1'b0 || resultOut !== 64'd0 || cfWrEn || ecfWrEn || ofWrEn || cfOut || ofOut)
      report("R11", "reset outputs", resultOut, 64'd0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R1 R7 shifts
    stepOp(1, 0, 1, 64'h8000_0000_0000_0001, 6'd1, 6'd0, 0, 0, 3'b111, "R1_R7 shl wide");
    stepOp(1, 0, 0, 64'hFFFF_FFFF_4000_0000, 6'd1, 6'd0, 0, 0, 3'b111, "R4_R7 shl narrow");
    stepOp(1, 1, 1, 64'h8000_0000_0000_0003, 6'd2, 6'd0, 0, 0, 3'b111, "R1_R7 shr wide");
    stepOp(1, 2, 0, 64'h0000_0000_8000_0010, 6'd4, 6'd0, 0, 1, 3'b111, "R1_R7 sar narrow");
    stepOp(1, 2, 1, 64'h8123_4567_89AB_CDEF, 6'd63, 6'd0, 0, 0, 3'b111, "R1 sar wide max");
    // R2 R8 rotates
    stepOp(1, 3, 1, 64'h8000_0000_0000_0001, 6'd1, 6'd0, 0, 0, 3'b111, "R2_R8 rol wide");
    stepOp(1, 4, 0, 64'h0000_0000_0000_0001, 6'd1, 6'd0, 0, 0, 3'b111, "R2_R8 ror narrow");
    stepOp(1, 4, 1, 64'h4000_0000_0000_0000, 6'd7, 6'd0, 0, 0, 3'b111, "R8 ror top bits differ");
    // R3 R9 through carry
    stepOp(1, 5, 0, 64'h0000_0000_8000_0000, 6'd1, 6'd0, 0, 1, 3'b111, "R3_R9 rcl narrow");
    stepOp(1, 6, 1, 64'h0000_0000_0000_0001, 6'd1, 6'd0, 0, 1, 3'b111, "R3_R9 rcr wide");
    stepOp(1, 5, 1, 64'h0123_4567_89AB_CDEF, 6'd63, 6'd0, 0, 1, 3'b111, "R3 rcl wide max");
    stepOp(1, 6, 0, 64'h0000_0000_1234_5678, 6'd31, 6'd0, 0, 0, 3'b111, "R3 rcr narrow max");
    // R5 R6 masking and source select
    stepOp(1, 0, 0, 64'h0000_0000_0000_00F1, 6'd32, 6'd0, 0, 1, 3'b111, "R5_R6 narrow amt 32 zero");
    stepOp(1, 3, 1, 64'hDEAD_BEEF_0000_1234, 6'd0, 6'd9, 0, 1, 3'b111, "R6 wide zero reg amt");
    stepOp(1, 1, 1, 64'hF000_0000_0000_0000, 6'd0, 6'd5, 1, 0, 3'b111, "R5 immediate amount");
    stepOp(1, 1, 0, 64'h0000_0000_F000_0000, 6'd3, 6'd37, 1, 0, 3'b111, "R5 narrow imm masked");
    // R10 partial requests
    stepOp(1, 0, 1, 64'h8000_0000_0000_0000, 6'd1, 6'd0, 0, 0, 3'b010, "R10 ecf only");
    stepOp(1, 4, 1, 64'h0000_0000_0000_0003, 6'd1, 6'd0, 0, 0, 3'b100, "R10 of only");
    // R12 code 7
    stepOp(1, 7, 0, 64'hAAAA_AAAA_5555_5555, 6'd3, 6'd0, 0, 1, 3'b111, "R12 pass through");
    // R11 idle
    stepOp(0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 6'd4, 6'd0, 0, 1, 3'b111, "R11 idle");

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] rs;
      rs = {$urandom, $urandom};
      stepOp(($urandom % 8) != 0, int'($urandom % 8), bit'($urandom % 2), rs,
             6'($urandom), 6'($urandom), bit'($urandom % 2), bit'($urandom % 2),
             3'($urandom), "R1_R2_R3_R4_R5_R6_R7_R8_R9_R10_R11_R12 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule